// File: doc/BRIEF.md
# SD Card Bus Clock Divider Controller

This block derives the SD card bus clock from a reference clock using a power-of-two divider and opens or closes the output through a glitch-free gate. The reference `clk_i` runs at twice the source rate, so a divide-by-1 setting makes `sd_clk_o` toggle on every reference edge. A divide-by-2^i setting holds each half period for 2^i reference cycles.

A caller issues a one-cycle write carrying the requested bus frequency and the current source frequency. The block first waits until the bus status input reports idle. It then closes the gate at a low phase of the output, loads the divider that was worked out, and reopens the gate. A zero request works as a stop: the gate stays closed and the reported frequency is zero. If the bus stays busy too long, the request is dropped, a timeout pulse is raised and the clock is left as it was. Divide-by-1 is an optional variant, and it is never chosen while the double-data-rate timing mode input is high.

Top module: `sdclk_divctl`

## Requirements
- R1: After reset `sd_clk_o` is low, `clk_on_o` is 0, `shift_o` is 9 (divide by 512), `actual_freq_o` is 0 and `busy_o` is 0.
- R2: For a non-zero request the divider exponent `shift_o` is the smallest i, from the lowest allowed value up to 9, for which `src_freq <= req_freq * 2^i`. It is 9 when no i qualifies. `actual_freq_o` is `src_freq >> shift_o`, rounded down.
- R3: Exponent 0 (bypass) may be picked only when parameter `BYPASS_OK` is 1 and `ddr_mode_i` was 0 at the write. Otherwise the lowest allowed exponent is 1.
- R4: A request of 0 leaves `clk_on_o` at 0 and `sd_clk_o` low, sets `actual_freq_o` to 0 and sets `shift_o` to 9.
- R5: `shift_o` never changes in a cycle where `clk_on_o` was 1 in the previous cycle and is still 1. The gate closes before a new divider is loaded and reopens only after the load.
- R6: While the gate is open, each half period of `sd_clk_o` lasts exactly 2^`shift_o` reference cycles. After the gate opens, the output starts with a full low phase. A high phase is never cut short, and `sd_clk_o` is low whenever `clk_on_o` is 0.
- R7: An accepted write changes nothing at the outputs until the bus reports idle. With `IDLE_IS_SET`=0, idle means `bus_stat_i`=0 (a busy flag). With `IDLE_IS_SET`=1, idle means `bus_stat_i`=1 (a ready flag).
- R8: If idle is not seen within `TMO_CYCLES` cycles after the write, `tmo_o` pulses for exactly one cycle, `busy_o` drops, and `shift_o`, `actual_freq_o` and the gate state stay unchanged.
- R9: `busy_o` is 1 from the cycle after an accepted write until the sequence ends. A write made while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (twice the source rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle request strobe |
| req_freq_i | input | FREQ_W | Requested bus frequency, 0 means stop |
| src_freq_i | input | FREQ_W | Source frequency used for the divider choice |
| ddr_mode_i | input | 1 | Double-data-rate timing mode active; forbids bypass |
| bus_stat_i | input | 1 | Bus status bit, polarity set by IDLE_IS_SET |
| sd_clk_o | output | 1 | Divided and gated card clock |
| clk_on_o | output | 1 | Gate open and output toggling |
| shift_o | output | SHW | Current divider exponent (divide by 2^shift_o) |
| actual_freq_o | output | FREQ_W | Resulting bus frequency, 0 when stopped |
| busy_o | output | 1 | A request is in progress |
| tmo_o | output | 1 | One-cycle pulse when the idle wait expires |

## Verification
The bench goes after the edges of the divider choice: an exact match between request and source, requests one below a power-of-two boundary, requests above the source, and requests so small that the exponent clamps at 9. A design with an off-by-one comparison would pick a divider that is one step too fast or too slow, and the measured period would show it. The bypass case is run with and without the double-data-rate mode; a design that ignored the mode would toggle at divide-by-1. Stalls are held both shorter and longer than the timeout. A design that loads early would change `shift_o` while the bus is busy, one that hangs would never drop `busy_o`, and one that honoured a write made during a stall would end up with the wrong divider.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // request sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_WAIT = 3'd1,
    SQ_GATE = 3'd2,
    SQ_LOAD = 3'd3,
    SQ_OPEN = 3'd4
  } sdclk_state_e;

endpackage

// File: rtl/sdclk_idle_wait.sv
module sdclk_idle_wait #(
  parameter int TMO_CYCLES  = 1000,
  parameter bit IDLE_IS_SET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic bus_stat_i,
  output logic bus_idle_o,
  output logic expire_o
);

  localparam int TW = $clog2(TMO_CYCLES + 1);

  logic [TW-1:0] wait_cnt_q;

  // polarity of the idle indication depends on the variant
  generate
    if (IDLE_IS_SET) begin : g_ready_flag
      assign bus_idle_o = bus_stat_i;
    end else begin : g_busy_flag
      assign bus_idle_o = ~bus_stat_i;
    end
  endgenerate

  assign expire_o = arm_i && !bus_idle_o && (wait_cnt_q == TW'(TMO_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt_q <= '0;
    end else if (!arm_i || expire_o) begin
      wait_cnt_q <= '0;
    end else begin
      wait_cnt_q <= wait_cnt_q + 1'b1;
    end
  end

  // R8: the window never runs past the limit
  p_wait_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt_q < TW'(TMO_CYCLES));

endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq
  import sdclk_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int MAX_SHIFT = 9,
  parameter bit BYPASS_OK = 1'b1,
  localparam int SHW      = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FREQ_W-1:0] req_freq_i,
  input  logic [FREQ_W-1:0] src_freq_i,
  input  logic              ddr_mode_i,
  input  logic              bus_idle_i,
  input  logic              expire_i,
  input  logic              running_i,
  output logic              arm_o,
  output logic              en_o,
  output logic [SHW-1:0]    shift_o,
  output logic [FREQ_W-1:0] actual_o,
  output logic              busy_o,
  output logic              tmo_o
);

  localparam int WW = FREQ_W + MAX_SHIFT;

  sdclk_state_e      st_q;
  logic [FREQ_W-1:0] req_q, src_q;
  logic              ddr_q;
  logic [SHW-1:0]    shift_q;
  logic [FREQ_W-1:0] act_q;
  logic              en_q, tmo_q;

  // smallest exponent whose divided source does not exceed the request
  function automatic logic [SHW-1:0] f_pick(input logic [FREQ_W-1:0] src,
                                            input logic [FREQ_W-1:0] req,
                                            input logic allow_one);
    logic [WW-1:0] lim;
    logic          found;
    f_pick = SHW'(MAX_SHIFT);
    found  = 1'b0;
    for (int i = 0; i <= MAX_SHIFT; i++) begin
      lim = WW'(req) << i;
      if (!found && (allow_one || i != 0) && (lim >= WW'(src))) begin
        f_pick = SHW'(i);
        found  = 1'b1;
      end
    end
  endfunction

  logic              allow_one;
  logic [SHW-1:0]    pick_w;
  logic              stop_req;
  logic              wait_pass;   // event: idle seen while waiting
  logic              accept;      // event: write taken

  assign allow_one = BYPASS_OK && !ddr_q;
  assign pick_w    = f_pick(src_q, req_q, allow_one);
  assign stop_req  = (req_q == '0);
  assign wait_pass = (st_q == SQ_WAIT) && bus_idle_i;
  assign accept    = (st_q == SQ_IDLE) && wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      req_q   <= '0;
      src_q   <= '0;
      ddr_q   <= 1'b0;
      shift_q <= SHW'(MAX_SHIFT);
      act_q   <= '0;
      en_q    <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            req_q <= req_freq_i;
            src_q <= src_freq_i;
            ddr_q <= ddr_mode_i;
            st_q  <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (wait_pass) begin
            en_q <= 1'b0;
            st_q <= SQ_GATE;
          end else if (expire_i) begin
            tmo_q <= 1'b1;
            st_q  <= SQ_IDLE;
          end
        end
        SQ_GATE: begin
          if (!running_i) st_q <= SQ_LOAD;
        end
        SQ_LOAD: begin
          if (stop_req) begin
            shift_q <= SHW'(MAX_SHIFT);
            act_q   <= '0;
            st_q    <= SQ_IDLE;
          end else begin
            shift_q <= pick_w;
            act_q   <= src_q >> pick_w;
            st_q    <= SQ_OPEN;
          end
        end
        SQ_OPEN: begin
          en_q <= 1'b1;
          st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign arm_o    = (st_q == SQ_WAIT);
  assign en_o     = en_q;
  assign shift_o  = shift_q;
  assign actual_o = act_q;
  assign busy_o   = (st_q != SQ_IDLE);
  assign tmo_o    = tmo_q;

  // R7: gating starts only after idle was observed
  p_gate_after_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_GATE && $past(st_q) == SQ_WAIT) |-> $past(bus_idle_i));

  // R5: the divider is loaded only with the generator stopped
  p_load_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_LOAD) |-> !running_i);

  // R3: no bypass when it is not permitted
  p_no_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_LOAD && !allow_one) |=> (shift_q != '0));

  // R4: a stop leaves the gate shut and reports zero
  p_stop_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_LOAD && stop_req) |=> (act_q == '0 && !en_q));

  // R8: the timeout flag is a single pulse
  p_tmo_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> !tmo_q);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int MAX_SHIFT = 9,
  localparam int SHW      = $clog2(MAX_SHIFT + 1),
  localparam int CW       = MAX_SHIFT + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [SHW-1:0] shift_i,
  output logic           running_o,
  output logic           sd_clk_o
);

  logic [CW-1:0] cnt_q;
  logic          run_q, clk_q;
  logic [CW-1:0] half_m1;
  logic          phase_end;  // event: a half period completes

  assign half_m1   = (CW'(1) << shift_i) - CW'(1);
  assign phase_end = (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      clk_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q <= 1'b1;
        clk_q <= 1'b0;
        cnt_q <= '0;
      end
    end else if (!en_i && !clk_q) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (phase_end) begin
      cnt_q <= '0;
      if (clk_q && !en_i) begin
        clk_q <= 1'b0;
        run_q <= 1'b0;
      end else begin
        clk_q <= ~clk_q;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign running_o = run_q;
  assign sd_clk_o  = clk_q;

  // checker counter for the length of each high phase
  logic [CW:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_len_q <= '0;
    else if (clk_q) hi_len_q <= hi_len_q + 1'b1;
    else            hi_len_q <= '0;
  end

  // R6: output is low while the gate is closed
  p_low_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_q);

  // R6: every high phase is complete, also when closing
  p_high_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |-> (hi_len_q == ((CW+1)'(1) << shift_i)));

  // R6: no rising edge on the cycle the gate shuts
  p_no_rise_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> run_q);

endmodule

// File: rtl/sdclk_divctl.sv
module sdclk_divctl #(
  parameter int FREQ_W      = 32,
  parameter int MAX_SHIFT   = 9,
  parameter int TMO_CYCLES  = 1000,
  parameter bit IDLE_IS_SET = 1'b0,
  parameter bit BYPASS_OK   = 1'b1,
  localparam int SHW        = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FREQ_W-1:0] req_freq_i,
  input  logic [FREQ_W-1:0] src_freq_i,
  input  logic              ddr_mode_i,
  input  logic              bus_stat_i,
  output logic              sd_clk_o,
  output logic              clk_on_o,
  output logic [SHW-1:0]    shift_o,
  output logic [FREQ_W-1:0] actual_freq_o,
  output logic              busy_o,
  output logic              tmo_o
);

  logic arm_w, bus_idle_w, expire_w, en_w, running_w;

  sdclk_idle_wait #(
    .TMO_CYCLES (TMO_CYCLES),
    .IDLE_IS_SET(IDLE_IS_SET)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_w),
    .bus_stat_i(bus_stat_i),
    .bus_idle_o(bus_idle_w),
    .expire_o  (expire_w)
  );

  sdclk_seq #(
    .FREQ_W   (FREQ_W),
    .MAX_SHIFT(MAX_SHIFT),
    .BYPASS_OK(BYPASS_OK)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .req_freq_i(req_freq_i),
    .src_freq_i(src_freq_i),
    .ddr_mode_i(ddr_mode_i),
    .bus_idle_i(bus_idle_w),
    .expire_i  (expire_w),
    .running_i (running_w),
    .arm_o     (arm_w),
    .en_o      (en_w),
    .shift_o   (shift_o),
    .actual_o  (actual_freq_o),
    .busy_o    (busy_o),
    .tmo_o     (tmo_o)
  );

  sdclk_gen #(
    .MAX_SHIFT(MAX_SHIFT)
  ) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .shift_i  (shift_o),
    .running_o(running_w),
    .sd_clk_o (sd_clk_o)
  );

  assign clk_on_o = running_w;

  // R5: the divider holds still while the clock runs
  p_shift_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_on_o && $past(clk_on_o)) |-> $stable(shift_o));

  // R6: output low whenever the gate is reported shut
  p_gate_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_on_o |-> !sd_clk_o);

endmodule

// File: tb/test_sdclk_divctl.sv
module test_sdclk_divctl;

  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] req = '0;
  logic [31:0] src = '0;
  logic        ddr = 1'b0;
  logic        bstat = 1'b0;
  logic        sd_clk, clk_on, busy, tmo;
  logic [3:0]  shift;
  logic [31:0] actual;

  int n_chk = 0;
  int n_err = 0;
  int mon_err = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  sdclk_divctl #(.TMO_CYCLES(TMO)) i_sdclk_divctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .req_freq_i(req),
    .src_freq_i(src), .ddr_mode_i(ddr), .bus_stat_i(bstat),
    .sd_clk_o(sd_clk), .clk_on_o(clk_on), .shift_o(shift),
    .actual_freq_o(actual), .busy_o(busy), .tmo_o(tmo)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected exponent, counted upward from the lowest allowed value
  function automatic int exp_shift(input longint s, input longint r, input bit one_ok);
    int k;
    if (r == 0) return 9;
    k = one_ok ? 0 : 1;
    while (k < 9 && (r * (64'd1 << k)) < s) k++;
    return k;
  endfunction

  // R5/R6 monitor: divider frozen while running, output low while shut
  logic       prev_on = 1'b0;
  logic [3:0] prev_sh = 4'd9;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_on && clk_on && shift != prev_sh) mon_err++;
      if (!clk_on && sd_clk) mon_err++;
    end
    prev_on = clk_on;
    prev_sh = shift;
  end

  task automatic write_req(input longint r, input longint s, input bit d);
    @(negedge clk);
    req = r[31:0]; src = s[31:0]; ddr = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 4000 && busy; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // measure period and high length of the output in reference cycles
  task automatic measure(output int per, output int hi);
    int n;
    per = 0; hi = 0; n = 0;
    while (sd_clk && n < 3000) begin @(negedge clk); n++; end
    while (!sd_clk && n < 3000) begin @(negedge clk); n++; end
    while (sd_clk && n < 3000) begin @(negedge clk); hi++; per++; n++; end
    while (!sd_clk && n < 3000) begin @(negedge clk); per++; n++; end
  endtask

  task automatic run_case(input longint r, input longint s, input bit d, input bit meas, input string tag);
    int es, per, hi;
    bit one_ok;
    one_ok = !d;
    es = exp_shift(s, r, one_ok);
    write_req(r, s, d);
    wait_done();
    chk(shift == es[3:0], {tag, " R2 shift"}, shift, es);
    chk(actual == 32'(s >> es), {tag, " R2 actual"}, actual, s >> es);
    chk(clk_on == 1'b1, {tag, " R5 reopened"}, clk_on, 1);
    if (meas) begin
      measure(per, hi);
      chk(per == (2 << es), {tag, " R6 period"}, per, 2 << es);
      chk(hi == (1 << es), {tag, " R6 high phase"}, hi, 1 << es);
    end
  endtask

  initial begin
    int per, hi, pulses;
    logic [3:0] sh_keep;
    logic [31:0] act_keep;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd_clk == 1'b0, "R1 sd_clk low", sd_clk, 0);
    chk(clk_on == 1'b0, "R1 gate shut", clk_on, 0);
    chk(shift == 4'd9, "R1 max divider", shift, 9);
    chk(actual == 0, "R1 actual zero", actual, 0);
    chk(busy == 1'b0, "R1 not busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed divider choice, R2 and R3
    run_case(1000, 1000, 1'b0, 1'b1, "R3 bypass exact");
    run_case(1000, 1000, 1'b1, 1'b1, "R3 ddr refuses bypass");
    run_case(999, 1000, 1'b0, 1'b1, "R2 just below");
    run_case(2000, 1000, 1'b0, 1'b1, "R2 above source");
    run_case(250, 1000, 1'b0, 1'b1, "R2 quarter");
    run_case(249, 1000, 1'b0, 1'b1, "R2 below quarter");
    run_case(1, 1000, 1'b0, 1'b1, "R2 clamp at 9");

    // R4 stop request
    write_req(0, 1000, 1'b0);
    wait_done();
    chk(clk_on == 1'b0, "R4 gate shut", clk_on, 0);
    chk(actual == 0, "R4 actual zero", actual, 0);
    chk(shift == 4'd9, "R4 divider max", shift, 9);
    hi = 0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (sd_clk) hi++; end
    chk(hi == 0, "R4 output stays low", hi, 0);

    // R7 stall, R9 ignored write during stall
    run_case(500, 1000, 1'b0, 1'b0, "R2 setup");
    bstat = 1'b1;
    write_req(125, 1000, 1'b0);
    repeat (10) @(negedge clk);
    write_req(1000, 1000, 1'b0);   // R9: must be ignored
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during stall", busy, 1);
    chk(shift == 4'd1, "R7 no load while busy", shift, 1);
    chk(clk_on == 1'b1, "R7 gate kept while busy", clk_on, 1);
    bstat = 1'b0;
    wait_done();
    chk(shift == 4'd3, "R9 first request wins", shift, 3);
    chk(actual == 125, "R9 actual of first request", actual, 125);

    // R8 timeout
    sh_keep = shift; act_keep = actual;
    bstat = 1'b1;
    write_req(1000, 1000, 1'b0);
    pulses = 0;
    for (int k = 0; k < TMO + 20; k++) begin @(negedge clk); if (tmo) pulses++; end
    chk(pulses == 1, "R8 one timeout pulse", pulses, 1);
    chk(busy == 1'b0, "R8 busy released", busy, 0);
    chk(shift == sh_keep, "R8 divider unchanged", shift, sh_keep);
    chk(actual == act_keep, "R8 actual unchanged", actual, act_keep);
    chk(clk_on == 1'b1, "R8 gate unchanged", clk_on, 1);
    bstat = 1'b0;
    measure(per, hi);
    chk(per == (2 << sh_keep), "R8 clock still runs", per, 2 << sh_keep);

    // constrained random requests, R2 R3 R6
    for (int it = 0; it < 16; it++) begin
      longint s, r;
      int sh;
      bit d;
      s  = longint'($urandom_range(32'd1000, 32'd200_000_000));
      sh = int'($urandom_range(0, 10));
      r  = (s >> sh) + longint'($urandom_range(0, 3));
      if (r == 0) r = 1;
      d  = 1'($urandom_range(0, 1));
      run_case(r, s, d, exp_shift(s, r, !d) <= 7, "R2 random");
    end

    chk(mon_err == 0, "R5 monitor divider and gate", mon_err, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule